// File: doc/BRIEF.md
# Word-to-Byte Bus Width Adapter

This block connects a 32-bit memory-mapped requester to a peripheral that has only an 8-bit data path. The requester presents a word address, a 32-bit write word, four byte-lane enables and a read or write strobe. The adapter holds it off with a wait-request signal while it replays the access as a run of single-byte cycles on the narrow side. The narrow side has a byte address, a select line, separate read and write strobes and 8-bit data in each direction.

A read always fetches the whole word. Four byte reads go out on consecutive clocks at ascending byte addresses, whatever the lane enables say, and the returned bytes are packed little-endian into the read word. A write is different: only the enabled lanes are sent, in ascending lane order, one per clock. A write with no lane enabled finishes at once without touching the peripheral.

The narrow peripheral returns read data one clock after it sees the read strobe. The adapter has no other timing on that side: the select line is its only handshake and there are no wait states.

Top module: `bus_width_adapter`

## Requirements
- R1: A synchronous active-high reset leaves the adapter idle: s_cs, s_rd and s_wr are low, and m_waitreq is low while no request is presented.
- R2: A master read produces exactly four slave read cycles on consecutive clocks, starting the clock after the request is first presented. Each has s_cs and s_rd high, and s_addr runs from m_addr*4 up to m_addr*4+3.
- R3: The byte enables have no effect on a read: a read with a single lane enabled still issues all four slave reads and returns the full word.
- R4: The slave byte returned for byte address m_addr*4+n is read on s_rdata one clock after its read strobe and is placed in m_rdata bits [8n+7:8n].
- R5: m_waitreq is high from the cycle a request is presented until its completion cycle, and low in that cycle. For a read, completion is the clock after the fourth slave read, so m_waitreq is high for exactly 5 cycles and m_rdata is valid when it falls. For a write with k enabled lanes (k>0), completion is the cycle of the last slave write, so m_waitreq is high for exactly k cycles.
- R6: A write sends one slave write for each set bit n of m_be, in ascending n, one per clock starting the clock after the request. Each has s_addr = m_addr*4+n and s_wdata = m_wdata[8n+7:8n]. Lanes whose enable is clear are never written.
- R7: A write with exactly one enabled lane keeps s_cs high for exactly one clock.
- R8: A write with m_be = 0 completes in the cycle it is presented, with m_waitreq low and no slave cycle.
- R9: s_rd and s_wr are never high together, and s_cs is high exactly when one of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_addr | input | 6 | Master word address |
| m_wdata | input | 32 | Master write word |
| m_be | input | 4 | Master byte-lane enables (bit n covers bits [8n+7:8n]) |
| m_read | input | 1 | Master read request, held until m_waitreq is low |
| m_write | input | 1 | Master write request, held until m_waitreq is low |
| m_waitreq | output | 1 | High while the request is not yet complete |
| m_rdata | output | 32 | Assembled read word, valid when m_waitreq falls on a read |
| s_addr | output | 8 | Slave byte address |
| s_cs | output | 1 | Slave select |
| s_rd | output | 1 | Slave read strobe |
| s_wr | output | 1 | Slave write strobe |
| s_wdata | output | 8 | Slave write byte |
| s_rdata | input | 8 | Slave read byte, valid the clock after s_rd |

## Verification
The most delicate cycle is the end of a read. In that cycle the last byte arrives on s_rdata and is passed straight into m_rdata, while m_waitreq falls and the master is free to place a new request in the very next cycle. The bench issues requests back to back with no idle cycle between them, mixing reads, narrow writes and empty writes. A cycle-accurate reference then judges each case. The reference checks that the completing word carries the fresh top byte rather than a stale one. It also checks that the next transaction's first slave cycle appears exactly one clock after its request and that no slave cycle appears that the reference did not schedule.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

    // Sequencer phases: waiting for a request, issuing byte cycles,
    // and the single trailing cycle in which the last read byte returns.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BYTES = 2'd1,
        PH_TAIL = 2'd2
    } bwa_phase_e;

    typedef enum logic {
        OP_LOAD = 1'b0,
        OP_STORE = 1'b1
    } bwa_op_e;

    // Fixed slave read latency in clocks (the sequencer assumes one).
    localparam int RD_LATENCY = 1;

    // True when no more than one bit of a lane mask is set.
    function automatic logic at_most_one(input logic [31:0] mask);
        return (mask & (mask - 32'd1)) == 32'd0;
    endfunction

endpackage

// File: rtl/bwa_lane_pick.sv
module bwa_lane_pick #(
    parameter int LANES = 4,
    localparam int LANE_W = $clog2(LANES)
) (
    input  logic [LANES-1:0]  mask,
    output logic [LANE_W-1:0] lane,
    output logic              any,
    output logic              last
);
    import bwa_pkg::*;

    // Lowest set lane wins: scanning from the top lets lower lanes overwrite.
    always_comb begin
        lane = '0;
        any  = 1'b0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (mask[i]) begin
                lane = LANE_W'(i);
                any  = 1'b1;
            end
        end
        last = any && at_most_one(32'(mask));
    end

endmodule

// File: rtl/bwa_rd_assemble.sv
module bwa_rd_assemble #(
    parameter int LANES = 4,
    parameter int BYTE_W = 8,
    localparam int LANE_W = $clog2(LANES),
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap_en,
    input  logic [LANE_W-1:0] cap_lane,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [DATA_W-1:0] word_out
);

    logic [BYTE_W-1:0] hold_q [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic hit;
        assign hit = cap_en && (cap_lane == LANE_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                hold_q[g] <= '0;
            end else if (hit) begin
                hold_q[g] <= byte_in;
            end
        end

        // The byte arriving this cycle bypasses its holding register so the
        // final lane is usable in the completion cycle itself.
        assign word_out[g*BYTE_W +: BYTE_W] = hit ? byte_in : hold_q[g];
    end

endmodule

// File: rtl/bwa_ctrl.sv
module bwa_ctrl #(
    parameter int LANES = 4,
    parameter int BYTE_W = 8,
    parameter int M_ADDR_W = 6,
    localparam int LANE_W = $clog2(LANES),
    localparam int DATA_W = LANES * BYTE_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [M_ADDR_W-1:0]        m_addr,
    input  logic [DATA_W-1:0]          m_wdata,
    input  logic [LANES-1:0]           m_be,
    input  logic                       m_read,
    input  logic                       m_write,
    output logic                       m_waitreq,
    output logic [M_ADDR_W+LANE_W-1:0] s_addr,
    output logic                       s_cs,
    output logic                       s_rd,
    output logic                       s_wr,
    output logic [BYTE_W-1:0]          s_wdata,
    output logic                       cap_en,
    output logic [LANE_W-1:0]          cap_lane
);
    import bwa_pkg::*;

    bwa_phase_e          phase_q;
    bwa_op_e             op_q;
    logic [LANES-1:0]    pend_q;
    logic [M_ADDR_W-1:0] word_q;
    logic [DATA_W-1:0]   wdata_q;
    logic                rd_ret_q;
    logic [LANE_W-1:0]   rd_lane_q;

    logic [LANE_W-1:0]   cur_lane;
    logic                cur_any;
    logic                cur_last;

    logic                take_rd;
    logic                take_wr;

    bwa_lane_pick #(.LANES(LANES)) u_pick (
        .mask (pend_q),
        .lane (cur_lane),
        .any  (cur_any),
        .last (cur_last)
    );

    assign take_rd = (phase_q == PH_IDLE) && m_read;
    assign take_wr = (phase_q == PH_IDLE) && !m_read && m_write && (m_be != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_IDLE;
            op_q      <= OP_LOAD;
            pend_q    <= '0;
            word_q    <= '0;
            wdata_q   <= '0;
            rd_ret_q  <= 1'b0;
            rd_lane_q <= '0;
        end else begin
            rd_ret_q  <= (phase_q == PH_BYTES) && (op_q == OP_LOAD);
            rd_lane_q <= cur_lane;
            unique case (phase_q)
                PH_IDLE: begin
                    if (take_rd) begin
                        op_q    <= OP_LOAD;
                        pend_q  <= '1;
                        word_q  <= m_addr;
                        phase_q <= PH_BYTES;
                    end else if (take_wr) begin
                        op_q    <= OP_STORE;
                        pend_q  <= m_be;
                        word_q  <= m_addr;
                        wdata_q <= m_wdata;
                        phase_q <= PH_BYTES;
                    end
                end
                PH_BYTES: begin
                    pend_q[cur_lane] <= 1'b0;
                    if (cur_last || !cur_any) begin
                        phase_q <= (op_q == OP_LOAD) ? PH_TAIL : PH_IDLE;
                    end
                end
                PH_TAIL: begin
                    phase_q <= PH_IDLE;
                end
                default: begin
                    phase_q <= PH_IDLE;
                end
            endcase
        end
    end

    always_comb begin
        s_cs    = (phase_q == PH_BYTES);
        s_rd    = s_cs && (op_q == OP_LOAD);
        s_wr    = s_cs && (op_q == OP_STORE);
        s_addr  = {word_q, cur_lane};
        s_wdata = wdata_q[int'(cur_lane)*BYTE_W +: BYTE_W];
        unique case (phase_q)
            PH_IDLE:  m_waitreq = m_read || (m_write && (m_be != '0));
            PH_BYTES: m_waitreq = (op_q == OP_LOAD) || !cur_last;
            default:  m_waitreq = 1'b0;
        endcase
    end

    assign cap_en   = rd_ret_q;
    assign cap_lane = rd_lane_q;

endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter #(
    parameter int LANES = 4,
    parameter int BYTE_W = 8,
    parameter int S_ADDR_W = 8
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic [S_ADDR_W-$clog2(LANES)-1:0]     m_addr,
    input  logic [LANES*BYTE_W-1:0]               m_wdata,
    input  logic [LANES-1:0]                      m_be,
    input  logic                                  m_read,
    input  logic                                  m_write,
    output logic                                  m_waitreq,
    output logic [LANES*BYTE_W-1:0]               m_rdata,
    output logic [S_ADDR_W-1:0]                   s_addr,
    output logic                                  s_cs,
    output logic                                  s_rd,
    output logic                                  s_wr,
    output logic [BYTE_W-1:0]                     s_wdata,
    input  logic [BYTE_W-1:0]                     s_rdata
);
    localparam int LANE_W   = $clog2(LANES);
    localparam int M_ADDR_W = S_ADDR_W - LANE_W;

    logic              cap_en;
    logic [LANE_W-1:0] cap_lane;

    bwa_ctrl #(
        .LANES    (LANES),
        .BYTE_W   (BYTE_W),
        .M_ADDR_W (M_ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .m_addr    (m_addr),
        .m_wdata   (m_wdata),
        .m_be      (m_be),
        .m_read    (m_read),
        .m_write   (m_write),
        .m_waitreq (m_waitreq),
        .s_addr    (s_addr),
        .s_cs      (s_cs),
        .s_rd      (s_rd),
        .s_wr      (s_wr),
        .s_wdata   (s_wdata),
        .cap_en    (cap_en),
        .cap_lane  (cap_lane)
    );

    bwa_rd_assemble #(
        .LANES  (LANES),
        .BYTE_W (BYTE_W)
    ) u_asm (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .cap_lane (cap_lane),
        .byte_in  (s_rdata),
        .word_out (m_rdata)
    );

endmodule

// File: rtl/bwa_checker.sv
module bwa_checker #(
    parameter int LANES = 4,
    parameter int S_ADDR_W = 8,
    localparam int LANE_W = $clog2(LANES)
) (
    input logic                clk,
    input logic                rst,
    input logic                m_read,
    input logic                m_write,
    input logic [LANES-1:0]    m_be,
    input logic                m_waitreq,
    input logic [S_ADDR_W-1:0] s_addr,
    input logic                s_cs,
    input logic                s_rd,
    input logic                s_wr
);

    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(s_rd && s_wr)); // R9

    AST_SELECT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        s_cs |-> (s_rd || s_wr)); // R9

    AST_STROBE_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        (s_rd || s_wr) |-> s_cs); // R9

    AST_READ_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (s_rd && $past(s_rd)) |-> (s_addr == $past(s_addr) + 1'b1)); // R2

    AST_READ_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        $fell(s_rd) |-> !m_waitreq); // R5

    AST_WRITE_LANE_ENABLED: assert property (@(posedge clk) disable iff (rst)
        s_wr |-> m_be[s_addr[LANE_W-1:0]]); // R6

    AST_WRITE_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        (s_wr && $past(s_wr)) |-> (s_addr > $past(s_addr))); // R6

    AST_EMPTY_WRITE_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        (m_write && !m_read && (m_be == '0) && !s_cs) |-> !m_waitreq); // R8

    AST_NO_REQUEST_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
        (!m_read && !m_write) |-> !m_waitreq); // R1

endmodule

bind bus_width_adapter bwa_checker #(
    .LANES    (LANES),
    .S_ADDR_W (S_ADDR_W)
) u_bwa_checker (
    .clk       (clk),
    .rst       (rst),
    .m_read    (m_read),
    .m_write   (m_write),
    .m_be      (m_be),
    .m_waitreq (m_waitreq),
    .s_addr    (s_addr),
    .s_cs      (s_cs),
    .s_rd      (s_rd),
    .s_wr      (s_wr)
);

// File: tb/tb_bus_width_adapter.sv
`timescale 1ns/1ps
module tb_bus_width_adapter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  m_addr = '0;
    logic [31:0] m_wdata = '0;
    logic [3:0]  m_be = '0;
    logic        m_read = 1'b0;
    logic        m_write = 1'b0;
    logic        m_waitreq;
    logic [31:0] m_rdata;
    logic [7:0]  s_addr;
    logic        s_cs, s_rd, s_wr;
    logic [7:0]  s_wdata;
    logic [7:0]  s_rdata = 8'h00;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit finished = 1'b0;
    bit mon_on = 1'b0;

    // Expected slave cycles: absolute cycle, address, write flag, data.
    int         q_cyc[$];
    logic [7:0] q_addr[$];
    bit         q_wr[$];
    logic [7:0] q_dat[$];

    logic [7:0] ref_mem [256];
    logic [7:0] slv_mem [256];

    bus_width_adapter dut (
        .clk(clk), .rst(rst), .m_addr(m_addr), .m_wdata(m_wdata), .m_be(m_be),
        .m_read(m_read), .m_write(m_write), .m_waitreq(m_waitreq), .m_rdata(m_rdata),
        .s_addr(s_addr), .s_cs(s_cs), .s_rd(s_rd), .s_wr(s_wr),
        .s_wdata(s_wdata), .s_rdata(s_rdata)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Narrow peripheral model: one clock of read latency, poison otherwise.
    always @(posedge clk) begin
        if (s_cs && s_wr) slv_mem[s_addr] <= s_wdata;
        s_rdata <= (s_cs && s_rd) ? slv_mem[s_addr] : 8'hEE;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Per-clock comparison against the scheduled slave cycles.
    always @(negedge clk) begin
        if (mon_on) begin
            #2;
            chk(!(s_rd && s_wr) && (s_cs == (s_rd || s_wr)), "R9", "strobe coherence",
                {29'd0, s_cs, s_rd, s_wr}, {29'd0, s_cs, s_cs && !s_wr, s_cs && !s_rd});
            if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
                if (q_wr[0]) begin
                    chk(s_cs && s_wr, "R6", "write strobe", {31'd0, s_wr}, 32'd1);
                    chk(s_addr == q_addr[0], "R6", "write address", {24'd0, s_addr}, {24'd0, q_addr[0]});
                    chk(s_wdata == q_dat[0], "R6", "write byte", {24'd0, s_wdata}, {24'd0, q_dat[0]});
                end else begin
                    chk(s_cs && s_rd, "R2", "read strobe", {31'd0, s_rd}, 32'd1);
                    chk(s_addr == q_addr[0], "R2", "read address", {24'd0, s_addr}, {24'd0, q_addr[0]});
                end
                void'(q_cyc.pop_front()); void'(q_addr.pop_front());
                void'(q_wr.pop_front());  void'(q_dat.pop_front());
            end else begin
                chk(!s_cs, "R7", "no unscheduled slave cycle (R8)", {31'd0, s_cs}, 32'd0);
            end
        end
    end

    task automatic go_idle();
        @(negedge clk);
        m_read = 1'b0; m_write = 1'b0;
    endtask

    task automatic wait_done(output int hi);
        #2;
        hi = 0;
        while (m_waitreq && hi < 20) begin
            hi++;
            @(negedge clk);
            #2;
        end
    endtask

    task automatic do_read(input logic [5:0] a, input logic [3:0] be, input string tag);
        int hi;
        logic [31:0] exp;
        @(negedge clk);
        m_read = 1'b1; m_write = 1'b0; m_addr = a; m_be = be; m_wdata = $urandom;
        for (int k = 0; k < 4; k++) begin
            q_cyc.push_back(cyc + 1 + k); q_addr.push_back({a, 2'(k)});
            q_wr.push_back(1'b0); q_dat.push_back(8'h00);
        end
        exp = {ref_mem[{a, 2'd3}], ref_mem[{a, 2'd2}], ref_mem[{a, 2'd1}], ref_mem[{a, 2'd0}]};
        wait_done(hi);
        chk(hi == 5, "R5", "read wait cycles", hi, 5);
        chk(m_rdata == exp, tag, "read word", m_rdata, exp);
    endtask

    task automatic do_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        int hi, k;
        @(negedge clk);
        m_read = 1'b0; m_write = 1'b1; m_addr = a; m_be = be; m_wdata = d;
        k = 0;
        for (int n = 0; n < 4; n++) begin
            if (be[n]) begin
                k++;
                q_cyc.push_back(cyc + k); q_addr.push_back({a, 2'(n)});
                q_wr.push_back(1'b1); q_dat.push_back(d[8*n +: 8]);
                ref_mem[{a, 2'(n)}] = d[8*n +: 8];
            end
        end
        wait_done(hi);
        if (be == 4'd0) chk(hi == 0, "R8", "empty write wait cycles", hi, 0);
        else            chk(hi == k, "R5", "write wait cycles", hi, k);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL R5 watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            ref_mem[i] = 8'(i * 7 + 3);
            slv_mem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        #2;
        chk(!s_cs && !s_rd && !s_wr, "R1", "strobes in reset", {29'd0, s_cs, s_rd, s_wr}, 0);
        chk(!m_waitreq, "R1", "waitreq in reset", {31'd0, m_waitreq}, 0);
        @(negedge clk);
        rst = 1'b0;
        mon_on = 1'b1;
        @(negedge clk);
        #2;
        chk(!s_cs && !m_waitreq, "R1", "idle after reset", {30'd0, s_cs, m_waitreq}, 0);

        do_read(6'h05, 4'hF, "R4");
        do_read(6'h10, 4'h1, "R3");
        do_read(6'h11, 4'h0, "R3");
        do_write(6'h05, 4'b0001, 32'hA1B2C3D4);     // R7: one slave cycle
        do_write(6'h06, 4'b1010, 32'h11223344);     // R6: lanes 1 and 3
        do_write(6'h07, 4'b0000, 32'hDEADBEEF);     // R8
        do_read(6'h07, 4'hF, "R8");
        do_write(6'h08, 4'b1111, 32'hCAFEF00D);
        do_read(6'h06, 4'h2, "R6");
        do_read(6'h05, 4'hF, "R7");
        do_write(6'h3F, 4'b1000, 32'h5A000000);
        do_read(6'h3F, 4'hF, "R4");
        do_read(6'h08, 4'hF, "R4");
        go_idle();
        repeat (3) go_idle();

        for (int it = 0; it < 40; it++) begin
            logic [5:0] a;
            logic [3:0] be;
            a  = 6'($urandom);
            be = 4'($urandom);
            if ($urandom % 2 == 0) do_write(a, be, $urandom);
            else                   do_read(a, be, "R4");
            if (it % 5 == 4) go_idle();
        end
        go_idle();
        repeat (4) go_idle();
        chk(q_cyc.size() == 0, "R2", "all scheduled slave cycles seen", q_cyc.size(), 0);
        mon_on = 1'b0;
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule